// File: doc/BRIEF.md
# NAND Flash Device Pin-Interface Front-End

This block is the device side of an asynchronous NAND flash pin interface, sampled by a local clock. It sorts each bus cycle into a command, an address or a data transfer, using a command-latch strobe, an address-latch strobe, an active-low write strobe and an active-low read strobe. Commands and the column address byte go into internal registers. A page buffer receives write data. A column counter sets the position for serial data in and out.

The block produces a separate output word and output enable for an external tri-state I/O pad, and an open-drain ready/busy pull-down. A small sequencer accepts read, program and erase command pairs. It holds ready/busy low for a fixed number of clock cycles for each operation. It honours chip select and write protect. The data width is 8 or 16 bits, set by a parameter. Commands and addresses always come from the low byte only.

Top module: `nand_bus_frontend`

## Requirements
- R1: On a write-strobe rising edge with the command latch high and the address latch low, the device captures io_in[7:0] as a command. In 16-bit mode, bits 15:8 play no part in decoding. The command codes are 0x00 (read setup), 0x30 (read start), 0x80 (program setup), 0x10 (program start), 0x60 (erase setup) and 0xD0 (erase start).
- R2: The first address cycle after a command loads the column counter from io_in[COL_W-1:0]. Later address cycles leave the column counter unchanged.
- R3: A write-strobe rising edge with both latch strobes high is ignored. It starts no operation and does not move the column.
- R4: A write-strobe rising edge with both latch strobes low writes io_in into the page buffer at the column counter, then increments the counter by one.
- R5: Each read-strobe falling edge puts the page-buffer word at the column counter on io_out, then increments the counter by one.
- R6: io_oe is high only while the chip is selected and the read strobe is low. It is low after reset.
- R7: A start command that follows its matching setup command pulls rb_pull_low high for exactly T_READ, T_PROG or T_ERASE clock cycles. A start command without its matching setup starts nothing.
- R8: Deselecting the chip during a program or erase does not shorten the busy period.
- R9: While wprot_n is low, program and erase start commands are refused. If wprot_n drops during a program or erase, busy is released on the next clock edge.
- R10: Bus cycles are ignored while the device is busy or while the chip is deselected.
- R11: Every accepted command cycle resets the address byte index to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip select, active low |
| cmd_latch | input | 1 | Command-latch strobe |
| addr_latch | input | 1 | Address-latch strobe |
| wr_n | input | 1 | Write strobe, active low, acts on rising edge |
| rd_n | input | 1 | Read strobe, active low, acts on falling edge |
| wprot_n | input | 1 | Write protect, active low |
| io_in | input | DATA_W | Value seen on the I/O pads |
| io_out | output | DATA_W | Word to drive on the I/O pads |
| io_oe | output | 1 | Pad output enable |
| rb_pull_low | output | 1 | High while the ready/busy line is pulled low |

## Verification
The assertions assume that the strobe pins are already synchronous to clk and stay stable for at least one clock around each edge. They also assume that a read strobe, once low, stays low for more than one cycle. The bench drives every pin on the falling clock edge. It holds each strobe level for whole cycles, keeps io_in constant across each write-strobe rising edge, and never raises both latch strobes except in the deliberate invalid-cycle test.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  typedef enum logic [1:0] {PEND_NONE, PEND_RD, PEND_PG, PEND_ER} pend_e;
  typedef enum logic [1:0] {OP_RD, OP_PG, OP_ER} op_e;

  localparam logic [7:0] CMD_RD_SETUP = 8'h00;
  localparam logic [7:0] CMD_RD_GO    = 8'h30;
  localparam logic [7:0] CMD_PG_SETUP = 8'h80;
  localparam logic [7:0] CMD_PG_GO    = 8'h10;
  localparam logic [7:0] CMD_ER_SETUP = 8'h60;
  localparam logic [7:0] CMD_ER_GO    = 8'hD0;
endpackage

// File: rtl/nfe_strobe_decode.sv
module nfe_strobe_decode (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic cmd_latch,
  input  logic addr_latch,
  input  logic wr_n,
  input  logic rd_n,
  input  logic hold,
  output logic cmd_cyc,
  output logic addr_cyc,
  output logic data_cyc,
  output logic rd_fall
);
  logic wr_prev, rd_prev, live, wr_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b1;
      rd_prev <= 1'b1;
    end else begin
      wr_prev <= wr_n;
      rd_prev <= rd_n;
    end
  end

  always_comb begin
    live     = !sel_n && !hold;
    wr_rise  = live && !wr_prev && wr_n;
    cmd_cyc  = wr_rise && cmd_latch && !addr_latch;
    addr_cyc = wr_rise && addr_latch && !cmd_latch;
    data_cyc = wr_rise && !addr_latch && !cmd_latch;
    rd_fall  = live && rd_prev && !rd_n;
  end

  // R5
  single_rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    rd_fall |=> !rd_fall);
endmodule

// File: rtl/nfe_busy_timer.sv
module nfe_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  input  logic             abort,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= load_val - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      busy <= 1'b0;
    end
  end

  // R7
  busy_only_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R9
  abort_releases_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy);
endmodule

// File: rtl/nfe_page_buf.sv
module nfe_page_buf #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/nand_bus_frontend.sv
module nand_bus_frontend
  import nand_fe_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COL_W   = 4,
  parameter int ADDR_N  = 3,
  parameter int T_READ  = 12,
  parameter int T_PROG  = 40,
  parameter int T_ERASE = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              cmd_latch,
  input  logic              addr_latch,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              wprot_n,
  input  logic [DATA_W-1:0] io_in,
  output logic [DATA_W-1:0] io_out,
  output logic              io_oe,
  output logic              rb_pull_low
);
  localparam int T_MAX = (T_ERASE > T_PROG) ? ((T_ERASE > T_READ) ? T_ERASE : T_READ)
                                            : ((T_PROG > T_READ) ? T_PROG : T_READ);
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam int IDX_W = $clog2(ADDR_N + 1);

  logic             cmd_cyc, addr_cyc, data_cyc, rd_fall;
  logic [7:0]       low_byte;
  logic [COL_W-1:0] col;
  logic [IDX_W-1:0] idx;
  pend_e            pend;
  op_e              kind;
  logic             start, abort;
  op_e              start_kind;
  logic [CNT_W-1:0] load_val;
  logic [DATA_W-1:0] rdata;

  generate
    if (DATA_W > 8) begin : g_wide
      assign low_byte = io_in[7:0];
    end else begin : g_narrow
      assign low_byte = io_in;
    end
  endgenerate

  nfe_strobe_decode u_dec (
    .clk(clk), .rst(rst), .sel_n(sel_n), .cmd_latch(cmd_latch),
    .addr_latch(addr_latch), .wr_n(wr_n), .rd_n(rd_n), .hold(rb_pull_low),
    .cmd_cyc(cmd_cyc), .addr_cyc(addr_cyc), .data_cyc(data_cyc), .rd_fall(rd_fall)
  );

  always_comb begin
    start      = 1'b0;
    start_kind = OP_RD;
    load_val   = CNT_W'(T_READ);
    if (cmd_cyc) begin
      if (low_byte == CMD_RD_GO && pend == PEND_RD) begin
        start = 1'b1;
      end else if (low_byte == CMD_PG_GO && pend == PEND_PG && wprot_n) begin
        start = 1'b1; start_kind = OP_PG; load_val = CNT_W'(T_PROG);
      end else if (low_byte == CMD_ER_GO && pend == PEND_ER && wprot_n) begin
        start = 1'b1; start_kind = OP_ER; load_val = CNT_W'(T_ERASE);
      end
    end
    abort = rb_pull_low && (kind != OP_RD) && !wprot_n;
  end

  nfe_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .load_val(load_val),
    .abort(abort), .busy(rb_pull_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= PEND_NONE;
      kind <= OP_RD;
      idx  <= '0;
      col  <= '0;
    end else begin
      if (start) kind <= start_kind;
      if (cmd_cyc) begin
        idx <= '0;
        case (low_byte)
          CMD_RD_SETUP: pend <= PEND_RD;
          CMD_PG_SETUP: pend <= PEND_PG;
          CMD_ER_SETUP: pend <= PEND_ER;
          default:      pend <= PEND_NONE;
        endcase
      end
      if (addr_cyc) begin
        if (idx == '0) col <= low_byte[COL_W-1:0];
        if (idx != IDX_W'(ADDR_N)) idx <= idx + 1'b1;
      end
      if (data_cyc || rd_fall) col <= col + 1'b1;
    end
  end

  nfe_page_buf #(.W(DATA_W), .AW(COL_W)) u_buf (
    .clk(clk), .rst(rst), .we(data_cyc), .waddr(col), .wdata(io_in),
    .re(rd_fall), .raddr(col), .rdata(rdata)
  );

  assign io_out = rdata;

  always_ff @(posedge clk) begin
    if (rst) io_oe <= 1'b0;
    else     io_oe <= !sel_n && !rd_n;
  end

  // R10
  busy_col_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    rb_pull_low |=> $stable(col));
  // R6
  oe_follows_pins_chk: assert property (@(posedge clk) disable iff (rst)
    io_oe |-> $past(!sel_n && !rd_n));
  // R4
  data_advances_col_chk: assert property (@(posedge clk) disable iff (rst)
    data_cyc |=> col == COL_W'($past(col) + 1'b1));
  // R11
  cmd_clears_idx_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_cyc |=> idx == '0);
endmodule

// File: tb/nand_bus_frontend_test.sv
module nand_bus_frontend_test;
  localparam int DW = 16, CW = 4, TR = 12, TP = 40, TE = 60;

  logic clk = 1'b0, rst = 1'b1;
  logic sel_n = 1'b0, cle = 1'b0, ale = 1'b0, wr_n = 1'b1, rd_n = 1'b1, wprot_n = 1'b1;
  logic [DW-1:0] io_in = '0;
  logic [DW-1:0] io_out;
  logic io_oe, rb;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nand_bus_frontend #(.DATA_W(DW), .COL_W(CW), .ADDR_N(3),
    .T_READ(TR), .T_PROG(TP), .T_ERASE(TE)) uut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .cmd_latch(cle), .addr_latch(ale),
    .wr_n(wr_n), .rd_n(rd_n), .wprot_n(wprot_n), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .rb_pull_low(rb)
  );

  function automatic logic [DW-1:0] wv(input int i);
    return 16'hC3A5 ^ DW'(i * 16'h1357);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic a, input logic [DW-1:0] v);
    @(negedge clk); cle = c; ale = a; io_in = v; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  // issue a start command and count busy cycles
  task automatic go_count(input logic [7:0] code, input int exp, input string tag,
                          input bit desel);
    int n = 0;
    @(negedge clk); cle = 1'b1; io_in = {8'h00, code}; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk); cle = 1'b0;
      if (desel) sel_n = 1'b1;
      if (rb) n++; else break;
    end
    sel_n = 1'b0;
    check(n == exp, tag, n, exp);
  endtask

  task automatic rd_word(input logic [DW-1:0] exp, input string tag);
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk);
    check(io_oe == 1'b1, "R6 oe during read", io_oe, 1);
    check(io_out == exp, tag, io_out, exp);
    rd_n = 1'b1;
    @(negedge clk);
    check(io_oe == 1'b0, "R6 oe after read", io_oe, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(rb == 1'b0, "R7 reset busy", rb, 0);
    check(io_oe == 1'b0, "R6 reset oe", io_oe, 0);
  endtask

  task automatic t_load_page;
    bus_wr(1, 0, 16'h5580);
    bus_wr(0, 1, 16'h0000);
    bus_wr(0, 1, 16'h0000);
    for (int i = 0; i < 8; i++) bus_wr(0, 0, wv(i));
    go_count(8'h10, TP, "R7 program busy length", 1'b0);
  endtask

  task automatic t_read_first;
    bus_wr(1, 0, 16'h7F00);  // R1 high byte must not matter
    bus_wr(0, 1, 16'h0003);
    bus_wr(0, 1, 16'h0009);  // R2 second byte leaves column
    go_count(8'h30, TR, "R7 read busy length", 1'b0);
    rd_word(wv(3), "R2 R5 first word");
    rd_word(wv(4), "R5 column advanced");
  endtask

  task automatic t_oe_deselect;
    @(negedge clk); sel_n = 1'b1; rd_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check(io_oe == 1'b0, "R6 oe deselected", io_oe, 0);
    rd_n = 1'b1; sel_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_idx_reset;
    bus_wr(1, 0, 16'h0000);
    bus_wr(0, 1, 16'h0002);
    bus_wr(1, 0, 16'h0000);
    bus_wr(0, 1, 16'h0006);  // R11 index back at zero
    go_count(8'h30, TR, "R7 read busy again", 1'b0);
    rd_word(wv(6), "R11 column from fresh first byte");
  endtask

  task automatic t_desel_cycle;
    bus_wr(1, 0, 16'h0000);
    @(negedge clk); sel_n = 1'b1;
    bus_wr(0, 1, 16'h000B);  // ignored
    @(negedge clk); sel_n = 1'b0;
    bus_wr(0, 1, 16'h0002);
    go_count(8'h30, TR, "R10 read after deselected cycle", 1'b0);
    rd_word(wv(2), "R10 deselected address ignored");
  endtask

  task automatic t_invalid;
    bus_wr(1, 0, 16'h0000);
    bus_wr(0, 1, 16'h0001);
    bus_wr(1, 1, 16'h0030);
    repeat (3) @(negedge clk);
    check(rb == 1'b0, "R3 both latches start nothing", rb, 0);
    go_count(8'h30, TR, "R7 read after invalid", 1'b0);
    rd_word(wv(1), "R3 column untouched");
  endtask

  task automatic t_orphan_go;
    go_count(8'h10, 0, "R7 program start without setup", 1'b0);
  endtask

  task automatic t_wp_block;
    @(negedge clk); wprot_n = 1'b0;
    bus_wr(1, 0, 16'h0060);
    go_count(8'hD0, 0, "R9 erase refused when protected", 1'b0);
    @(negedge clk); wprot_n = 1'b1;
  endtask

  task automatic t_erase_desel;
    bus_wr(1, 0, 16'h0060);
    bus_wr(0, 1, 16'h0001);
    go_count(8'hD0, TE, "R8 erase survives deselect", 1'b1);
  endtask

  task automatic t_busy_ignore;
    bus_wr(1, 0, 16'h0000);
    bus_wr(0, 1, 16'h0005);
    bus_wr(1, 0, 16'h0060);
    bus_wr(1, 0, 16'h00D0);
    bus_wr(0, 0, 16'hDEAD);  // during busy, must be ignored
    for (int k = 0; k < 200 && rb; k++) @(negedge clk);
    bus_wr(1, 0, 16'h0000);
    bus_wr(0, 1, 16'h0005);
    go_count(8'h30, TR, "R10 read after erase", 1'b0);
    rd_word(wv(5), "R10 write during busy ignored");
  endtask

  task automatic t_abort;
    bus_wr(1, 0, 16'h0080);
    bus_wr(0, 1, 16'h0000);
    bus_wr(1, 0, 16'h0010);
    repeat (4) @(negedge clk);
    check(rb == 1'b1, "R9 program running", rb, 1);
    wprot_n = 1'b0;
    @(negedge clk);
    check(rb == 1'b0, "R9 abort on protect", rb, 0);
    wprot_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_load_page();
    t_read_first();
    t_oe_deselect();
    t_idx_reset();
    t_desel_cycle();
    t_invalid();
    t_orphan_go();
    t_wp_block();
    t_erase_desel();
    t_busy_ignore();
    t_abort();
    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !finished; c++) @(negedge clk);
    if (!finished) check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule